// File: doc/BRIEF.md
# Vectored interrupt entry sequencer

This block sits on the processor side of a shared bus and carries out the hardware part of entering an interrupt handler. It waits for an instruction boundary. If a device holds its request line high at that point, the block raises the grant line. The device then drives the address of its vector onto the address lines and marks it valid. The block takes that address and reads two words from it. It saves the interrupted program counter and status word on the memory stack. It then loads the words it read as the new program counter and status word, so execution resumes directly in the device's handler.

Each vector is a four-byte slot in a small table in low memory. The first word of the slot is the handler address and the second word is the handler's status word. Memory is reached through a single word-wide read/write port. That port holds every request until the memory answers with ready. An odd vector address is not serviced: the block reports it and drops back to idle with no side effects.

Top module: `vec_entry_seq`

## Requirements
- R1: The grant output rises only in the cycle after one in which the sequencer was idle, the boundary strobe was high and the request was high. With the strobe low or the request low, grant stays low.
- R2: While grant is high, the vector address is taken in the first cycle in which vector-valid is high. Grant is low from the following cycle on.
- R3: For an even vector V, the sequencer makes two reads in this order. It reads the new program counter at address V, then the new status word at address V+2.
- R4: After the reads come two writes. With stack pointer S at entry, the old status word goes to S-2 and then the old program counter goes to S-4. The stack pointer ends at S-4, so the old program counter is on top.
- R5: When the entry completes, the program counter and status word outputs show the two words read in R3. The done pulse is high for one cycle in that same cycle.
- R6: A memory request whose ready is low is held the next cycle with the same address, direction and data, and the sequence does not advance.
- R7: A vector with address bit 0 set raises the error pulse in the cycle after capture. It makes no memory access, leaves the program counter, status word and stack pointer unchanged, and returns to idle.
- R8: After a grant, no further grant is issued until the request has been seen low for at least one cycle, even if the strobe is pulsed.
- R9: Busy is high from the cycle grant rises until the cycle in which the new program counter appears or the error pulse appears, and low otherwise.
- R10: After reset the program counter, status word and stack pointer hold their reset parameters, and grant, busy, done and error are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary_i | input | 1 | Instruction boundary strobe; requests are only sampled here |
| bus_req_i | input | 1 | Device interrupt request |
| bus_grant_o | output | 1 | Grant back to the requesting device |
| vec_valid_i | input | 1 | Device marks the vector address as valid |
| vec_addr_i | input | W | Vector address driven by the device |
| mem_addr_o | output | W | Byte address of the memory access |
| mem_rd_o | output | 1 | Memory read request |
| mem_wr_o | output | 1 | Memory write request |
| mem_wdata_o | output | W | Write data |
| mem_rdata_i | input | W | Read data, valid when ready is high |
| mem_ready_i | input | 1 | Memory completes the current access this cycle |
| pc_o | output | W | Program counter register |
| psw_o | output | W | Processor status word register |
| sp_o | output | W | Stack pointer register |
| busy_o | output | 1 | Interrupt entry in progress |
| entry_done_o | output | 1 | One-cycle pulse when the new program counter is loaded |
| vec_err_o | output | 1 | One-cycle pulse for a rejected odd vector |

## Verification
A sequencer stuck in or skipping a state shows at the memory port within one access. The bench then sees a missing, repeated or reordered address, or a stack write carrying the wrong register. A wrong stack pointer or held-back register load shows in the cycle the done pulse appears, because the bench compares all three registers there. A lost re-arm condition shows as a grant within one cycle of a boundary strobe while the request was never released. A stuck grant shows one cycle after vector-valid.

// File: rtl/vent_pkg.sv
package vent_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GRANT,
    ST_RD_PC,
    ST_RD_PSW,
    ST_PUSH_PSW,
    ST_PUSH_PC
  } vent_state_e;
endpackage

// File: rtl/vent_grant.sv
module vent_grant #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         idle_i,
  input  logic         boundary_i,
  input  logic         req_i,
  input  logic         vec_valid_i,
  input  logic [W-1:0] vec_addr_i,
  output logic         start_o,
  output logic         capture_o,
  output logic         cap_odd_o,
  output logic         grant_o,
  output logic [W-1:0] vec_o
);
  logic         armed_q;
  logic         grant_q;
  logic [W-1:0] vec_q;

  assign start_o   = idle_i && boundary_i && req_i && armed_q;
  assign capture_o = grant_q && vec_valid_i;
  assign cap_odd_o = vec_addr_i[0];
  assign grant_o   = grant_q;
  assign vec_o     = vec_q;

  // a grant consumes the request; it re-arms once the line is seen low
  always_ff @(posedge clk) begin
    if (rst)          armed_q <= 1'b1;
    else if (start_o) armed_q <= 1'b0;
    else if (!req_i)  armed_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)            grant_q <= 1'b0;
    else if (start_o)   grant_q <= 1'b1;
    else if (capture_o) grant_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)            vec_q <= '0;
    else if (capture_o) vec_q <= vec_addr_i;
  end

  // R1
  grant_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_q) |-> $past(boundary_i && req_i && idle_i));

  // R2
  grant_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (grant_q && vec_valid_i) |=> !grant_q);
endmodule

// File: rtl/vent_ctrl.sv
module vent_ctrl
  import vent_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         capture_i,
  input  logic         cap_odd_i,
  input  logic [W-1:0] vec_i,
  input  logic [W-1:0] pc_i,
  input  logic [W-1:0] psw_i,
  input  logic [W-1:0] sp_i,
  input  logic [W-1:0] mem_rdata_i,
  input  logic         mem_ready_i,
  output logic         idle_o,
  output logic         busy_o,
  output logic [W-1:0] mem_addr_o,
  output logic         mem_rd_o,
  output logic         mem_wr_o,
  output logic [W-1:0] mem_wdata_o,
  output logic         sp_dec_o,
  output logic         load_o,
  output logic [W-1:0] new_pc_o,
  output logic [W-1:0] new_psw_o,
  output logic         done_o,
  output logic         err_o
);
  localparam int           STEP   = W / 8;
  localparam logic [W-1:0] STEP_W = W'(STEP);

  vent_state_e  st_q, st_d;
  logic [W-1:0] new_pc_q, new_psw_q;
  logic         done_q, err_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:     if (start_i) st_d = ST_GRANT;
      ST_GRANT:    if (capture_i) st_d = cap_odd_i ? ST_IDLE : ST_RD_PC;
      ST_RD_PC:    if (mem_ready_i) st_d = ST_RD_PSW;
      ST_RD_PSW:   if (mem_ready_i) st_d = ST_PUSH_PSW;
      ST_PUSH_PSW: if (mem_ready_i) st_d = ST_PUSH_PC;
      ST_PUSH_PC:  if (mem_ready_i) st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    mem_rd_o    = 1'b0;
    mem_wr_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (st_q)
      ST_RD_PC: begin
        mem_rd_o   = 1'b1;
        mem_addr_o = vec_i;
      end
      ST_RD_PSW: begin
        mem_rd_o   = 1'b1;
        mem_addr_o = vec_i + STEP_W;
      end
      ST_PUSH_PSW: begin
        mem_wr_o    = 1'b1;
        mem_addr_o  = sp_i - STEP_W;
        mem_wdata_o = psw_i;
      end
      ST_PUSH_PC: begin
        mem_wr_o    = 1'b1;
        mem_addr_o  = sp_i - STEP_W;
        mem_wdata_o = pc_i;
      end
      default: ;
    endcase
  end

  assign sp_dec_o = mem_ready_i && (st_q == ST_PUSH_PSW || st_q == ST_PUSH_PC);
  assign load_o   = mem_ready_i && (st_q == ST_PUSH_PC);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      new_pc_q  <= '0;
      new_psw_q <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= load_o;
      err_q  <= (st_q == ST_GRANT) && capture_i && cap_odd_i;
      if (st_q == ST_RD_PC  && mem_ready_i) new_pc_q  <= mem_rdata_i;
      if (st_q == ST_RD_PSW && mem_ready_i) new_psw_q <= mem_rdata_i;
    end
  end

  assign idle_o    = (st_q == ST_IDLE);
  assign busy_o    = (st_q != ST_IDLE);
  assign new_pc_o  = new_pc_q;
  assign new_psw_o = new_psw_q;
  assign done_o    = done_q;
  assign err_o     = err_q;

  // R6
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((mem_rd_o || mem_wr_o) && !mem_ready_i) |=>
      ($stable(mem_addr_o) && $stable(mem_rd_o) && $stable(mem_wr_o) && $stable(mem_wdata_o)));

  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |-> (!mem_rd_o && !mem_wr_o && !busy_o));
endmodule

// File: rtl/vent_regs.sv
module vent_regs #(
  parameter int           W       = 16,
  parameter logic [W-1:0] PC_RST  = 'h0100,
  parameter logic [W-1:0] PSW_RST = 'h0000,
  parameter logic [W-1:0] SP_RST  = 'h01F0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sp_dec_i,
  input  logic         load_i,
  input  logic [W-1:0] new_pc_i,
  input  logic [W-1:0] new_psw_i,
  output logic [W-1:0] pc_o,
  output logic [W-1:0] psw_o,
  output logic [W-1:0] sp_o
);
  localparam logic [W-1:0] STEP_W = W'(W / 8);

  logic [W-1:0] pc_q, psw_q, sp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= PC_RST;
      psw_q <= PSW_RST;
      sp_q  <= SP_RST;
    end else begin
      if (sp_dec_i) sp_q <= sp_q - STEP_W;
      if (load_i) begin
        pc_q  <= new_pc_i;
        psw_q <= new_psw_i;
      end
    end
  end

  assign pc_o  = pc_q;
  assign psw_o = psw_q;
  assign sp_o  = sp_q;

  // R4
  sp_step_chk: assert property (@(posedge clk) disable iff (rst)
    sp_dec_i |=> (sp_o == $past(sp_o) - STEP_W));

  // R7
  reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !sp_dec_i) |=> ($stable(pc_o) && $stable(psw_o) && $stable(sp_o)));
endmodule

// File: rtl/vec_entry_seq.sv
module vec_entry_seq #(
  parameter int           W       = 16,
  parameter logic [W-1:0] PC_RST  = 'h0100,
  parameter logic [W-1:0] PSW_RST = 'h0000,
  parameter logic [W-1:0] SP_RST  = 'h01F0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         boundary_i,
  input  logic         bus_req_i,
  output logic         bus_grant_o,
  input  logic         vec_valid_i,
  input  logic [W-1:0] vec_addr_i,
  output logic [W-1:0] mem_addr_o,
  output logic         mem_rd_o,
  output logic         mem_wr_o,
  output logic [W-1:0] mem_wdata_o,
  input  logic [W-1:0] mem_rdata_i,
  input  logic         mem_ready_i,
  output logic [W-1:0] pc_o,
  output logic [W-1:0] psw_o,
  output logic [W-1:0] sp_o,
  output logic         busy_o,
  output logic         entry_done_o,
  output logic         vec_err_o
);
  logic         idle, start, capture, cap_odd, sp_dec, load;
  logic [W-1:0] vec, new_pc, new_psw;

  vent_grant #(.W(W)) u_grant (
    .clk        (clk),
    .rst        (rst),
    .idle_i     (idle),
    .boundary_i (boundary_i),
    .req_i      (bus_req_i),
    .vec_valid_i(vec_valid_i),
    .vec_addr_i (vec_addr_i),
    .start_o    (start),
    .capture_o  (capture),
    .cap_odd_o  (cap_odd),
    .grant_o    (bus_grant_o),
    .vec_o      (vec)
  );

  vent_ctrl #(.W(W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start),
    .capture_i  (capture),
    .cap_odd_i  (cap_odd),
    .vec_i      (vec),
    .pc_i       (pc_o),
    .psw_i      (psw_o),
    .sp_i       (sp_o),
    .mem_rdata_i(mem_rdata_i),
    .mem_ready_i(mem_ready_i),
    .idle_o     (idle),
    .busy_o     (busy_o),
    .mem_addr_o (mem_addr_o),
    .mem_rd_o   (mem_rd_o),
    .mem_wr_o   (mem_wr_o),
    .mem_wdata_o(mem_wdata_o),
    .sp_dec_o   (sp_dec),
    .load_o     (load),
    .new_pc_o   (new_pc),
    .new_psw_o  (new_psw),
    .done_o     (entry_done_o),
    .err_o      (vec_err_o)
  );

  vent_regs #(.W(W), .PC_RST(PC_RST), .PSW_RST(PSW_RST), .SP_RST(SP_RST)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .sp_dec_i (sp_dec),
    .load_i   (load),
    .new_pc_i (new_pc),
    .new_psw_i(new_psw),
    .pc_o     (pc_o),
    .psw_o    (psw_o),
    .sp_o     (sp_o)
  );

  // R9
  grant_busy_chk: assert property (@(posedge clk) disable iff (rst)
    bus_grant_o |-> busy_o);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> bus_grant_o);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    entry_done_o |-> (!busy_o && !vec_err_o));
endmodule

// File: tb/vec_entry_seq_tb_top.sv
module vec_entry_seq_tb_top;
  localparam int          W   = 16;
  localparam logic [15:0] PC0 = 16'h0100;
  localparam logic [15:0] PS0 = 16'h0000;
  localparam logic [15:0] SP0 = 16'h01F0;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst, boundary, req, vvalid, ready;
  logic [W-1:0] vaddr;
  logic [W-1:0] maddr, wdata, rdata, pc, psw, sp;
  logic         grant, mrd, mwr, busy, done, err;

  vec_entry_seq #(.W(W), .PC_RST(PC0), .PSW_RST(PS0), .SP_RST(SP0)) dut_i (
    .clk(clk), .rst(rst), .boundary_i(boundary), .bus_req_i(req), .bus_grant_o(grant),
    .vec_valid_i(vvalid), .vec_addr_i(vaddr), .mem_addr_o(maddr), .mem_rd_o(mrd),
    .mem_wr_o(mwr), .mem_wdata_o(wdata), .mem_rdata_i(rdata), .mem_ready_i(ready),
    .pc_o(pc), .psw_o(psw), .sp_o(sp), .busy_o(busy), .entry_done_o(done), .vec_err_o(err)
  );

  function automatic logic [15:0] tbl_word(input int i);
    return 16'((i * 40503 + 12345) & 16'hFFFF);
  endfunction

  function automatic logic [15:0] exp_sp(input logic [15:0] s);
    return s - 16'd4;
  endfunction

  // memory model: word array over byte addresses 0..0x1FF
  logic [15:0] mem [0:255];
  assign rdata = mem[maddr[8:1]];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= tbl_word(i);
    end else if (mwr && ready) begin
      mem[maddr[8:1]] <= wdata;
    end
  end

  initial begin
    ready = 1'b1;
    forever begin
      @(posedge clk);
      #2;
      ready = ($urandom % 3) != 0;
    end
  end

  // access monitor with its own counters (R6 hold, log of accepted accesses)
  int          n_acc = 0;
  logic [15:0] log_addr [0:63];
  logic [15:0] log_data [0:63];
  logic        log_wr   [0:63];
  int          mon_checks = 0, mon_fails = 0;
  logic        pend = 1'b0, p_rd = 1'b0, p_wr = 1'b0;
  logic [15:0] p_addr = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (pend) begin
        mon_checks++;
        if (maddr !== p_addr || mrd !== p_rd || mwr !== p_wr) begin
          mon_fails++;
          $display("FAIL R6 held access changed: addr %h rd %b wr %b expected addr %h rd %b wr %b",
                   maddr, mrd, mwr, p_addr, p_rd, p_wr);
        end
      end
      pend   = (mrd || mwr) && !ready;
      p_addr = maddr;
      p_rd   = mrd;
      p_wr   = mwr;
      if ((mrd || mwr) && ready) begin
        log_addr[n_acc % 64] = maddr;
        log_data[n_acc % 64] = wdata;
        log_wr[n_acc % 64]   = mwr;
        n_acc++;
      end
    end
  end

  int checks = 0, fails = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one interrupt entry; hold keeps the request high afterwards
  task automatic run_entry(input logic [15:0] vec, input int vdelay, input bit hold,
                           output bit got_done, output bit got_err);
    got_done = 0;
    got_err  = 0;
    @(negedge clk);
    req = 1'b1;
    boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
    check("R1 grant after strobe", 32'(grant), 32'd1);
    check("R9 busy with grant", 32'(busy), 32'd1);
    for (int k = 0; k < vdelay; k++) begin
      @(negedge clk);
      check("R2 grant held until vector", 32'(grant), 32'd1);
    end
    vaddr  = vec;
    vvalid = 1'b1;
    @(negedge clk);
    vvalid = 1'b0;
    vaddr  = 16'($urandom);
    check("R2 grant dropped after capture", 32'(grant), 32'd0);
    for (int k = 0; k < 200; k++) begin
      if (done || err) break;
      check("R9 busy during entry", 32'(busy), 32'd1);
      @(negedge clk);
    end
    got_done = done;
    got_err  = err;
    check("R9 busy low at end", 32'(busy), 32'd0);
    if (!hold) begin
      req = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic do_entry(input logic [15:0] vec, input int vdelay, input bit hold);
    logic [15:0] pc0, ps0, sp0;
    int n0;
    bit d, e;
    pc0 = pc; ps0 = psw; sp0 = sp; n0 = n_acc;
    run_entry(vec, vdelay, hold, d, e);
    if (vec[0]) begin
      check("R7 error pulse", 32'(e), 32'd1);
      check("R7 no done", 32'(d), 32'd0);
      check("R7 no memory access", 32'(n_acc - n0), 32'd0);
      check("R7 pc kept", 32'(pc), 32'(pc0));
      check("R7 psw kept", 32'(psw), 32'(ps0));
      check("R7 sp kept", 32'(sp), 32'(sp0));
    end else begin
      check("R5 done pulse", 32'(d), 32'd1);
      check("R5 new pc", 32'(pc), 32'(tbl_word(int'(vec >> 1))));
      check("R5 new psw", 32'(psw), 32'(tbl_word(int'(vec >> 1) + 1)));
      check("R4 sp after pushes", 32'(sp), 32'(exp_sp(sp0)));
      check("R3 access count", 32'(n_acc - n0), 32'd4);
      check("R3 first read addr", 32'(log_addr[n0 % 64]), 32'(vec));
      check("R3 first is read", 32'(log_wr[n0 % 64]), 32'd0);
      check("R3 second read addr", 32'(log_addr[(n0 + 1) % 64]), 32'(vec + 16'd2));
      check("R3 second is read", 32'(log_wr[(n0 + 1) % 64]), 32'd0);
      check("R4 psw push addr", 32'(log_addr[(n0 + 2) % 64]), 32'(sp0 - 16'd2));
      check("R4 psw push data", 32'(log_data[(n0 + 2) % 64]), 32'(ps0));
      check("R4 psw push is write", 32'(log_wr[(n0 + 2) % 64]), 32'd1);
      check("R4 pc push addr", 32'(log_addr[(n0 + 3) % 64]), 32'(sp0 - 16'd4));
      check("R4 pc push data", 32'(log_data[(n0 + 3) % 64]), 32'(pc0));
      check("R4 old pc on top", 32'(mem[sp[8:1]]), 32'(pc0));
    end
    @(negedge clk);
    check("R5 done is one cycle", 32'(done), 32'd0);
    check("R7 error is one cycle", 32'(err), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks + 1, fails + mon_fails + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; boundary = 1'b0; req = 1'b0; vvalid = 1'b0; vaddr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 reset pc", 32'(pc), 32'(PC0));
    check("R10 reset psw", 32'(psw), 32'(PS0));
    check("R10 reset sp", 32'(sp), 32'(SP0));
    check("R10 reset grant", 32'(grant), 32'd0);
    check("R10 reset busy", 32'(busy), 32'd0);
    check("R10 reset done", 32'(done), 32'd0);
    check("R10 reset error", 32'(err), 32'd0);

    // R1: request without strobe, strobe without request
    req = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R1 no grant without strobe", 32'(grant), 32'd0);
    end
    req = 1'b0;
    boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
    @(negedge clk);
    check("R1 no grant without request", 32'(grant), 32'd0);

    do_entry(16'h0004, 0, 1'b0);
    do_entry(16'h003C, 3, 1'b0);
    do_entry(16'h0009, 1, 1'b0);

    // R8: request left high after an entry must not be granted again
    do_entry(16'h0010, 0, 1'b1);
    boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check("R8 no regrant while request held", 32'(grant), 32'd0);
      check("R8 stays idle", 32'(busy), 32'd0);
      @(negedge clk);
    end
    req = 1'b0;
    @(negedge clk);
    do_entry(16'h0000, 2, 1'b0);

    for (int it = 0; it < 24; it++) begin
      int idx;
      bit odd;
      idx = int'($urandom % 16);
      odd = ($urandom % 5) == 0;
      do_entry(16'(idx * 4 + (odd ? 1 : 0)), int'($urandom % 3), 1'b0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks, fails + mon_fails);
    $finish;
  end
endmodule